// File: doc/BRIEF.md
# Symmetric PWM Carrier Counter with Sync Chaining

This block is the time-base of one PWM channel. A counter climbs from zero to a programmable period value and then falls back to zero, so it produces a triangular, symmetric carrier. With a period of P the full carrier repeats every 2P clocks; a period of 600 gives a 1200-clock carrier. Compare stages downstream read the counter value and the two event strobes, one at the valley and one at the peak, to build center-aligned waveforms.

Software reaches the block through a simple write port. A period write lands in a holding register and reaches the running carrier only at the next valley, so a new period never breaks a half-cycle. A phase value can be forced into the counter by a sync pulse when phase loading is enabled. This lets several channels share one carrier with fixed offsets. The sync output sends either a valley pulse or the incoming sync pulse to the next channel in a chain.

Top module: `pwm_tbase`

## Requirements
- R1: After reset the counter is 0, `dir_up` is 1, the period is the `RESET_PRD` parameter, the phase value is 0, phase loading is off and the sync output source is the valley pulse.
- R2: With a period P > 0 and no phase load, the counter steps 0,1,...,P,P-1,...,1,0 and repeats, so each carrier lasts 2P clocks.
- R3: `dir_up` shows the direction of the latest step. It is 1 on the rising half, including the peak, and 0 on the falling half, including the valley. It falls on the clock after the counter equals the period and rises on the clock after the valley.
- R4: `zero_evt` is high exactly while the counter is 0. `period_evt` is high exactly while the counter equals the active, nonzero period. For P > 0 each lasts one clock per occurrence.
- R5: A write to address 0 sets only the pending period. The active period copies it on the clock edge at which the counter is 0, so the carrier in progress keeps its old peak.
- R6: Address 1 holds the phase value. Bit 0 of the control word at address 2 enables phase loading. When it is 1 and `sync_in` is high at a clock edge, the counter takes the phase value and `dir_up` becomes 1 at that edge.
- R7: While bit 0 of the control word is 0, `sync_in` has no effect on the counter or on `dir_up`.
- R8: Bit 1 of the control word picks the sync output. With 0, `sync_out` equals `zero_evt`. With 1, `sync_out` follows `sync_in` with no register delay.
- R9: If a phase load places the counter at or above the active period while rising, the next step turns the counter downward.
- R10: With an active period of 0, the counter stays at 0 and `dir_up` stays 1.
- R11: A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 phase, 2 control |
| wr_data | input | CW | Write data |
| sync_in | input | 1 | Incoming sync pulse |
| count | output | CW | Carrier counter value |
| zero_evt | output | 1 | High while the counter is 0 |
| period_evt | output | 1 | High while the counter equals the active period |
| dir_up | output | 1 | Direction of the latest step, 1 for up |
| sync_out | output | 1 | Chained sync pulse |

## Verification
The bench builds the block with `CW` = 8 and `RESET_PRD` = 5. These values keep whole carriers short, so the bench can walk through many of them step by step. They also make the largest period, 255, reachable, so a full-width triangle runs with no wrap of the counter. Small periods of 0, 3 and 4 bring the held-at-zero case, a phase load above the peak and a period change during a carrier within a few dozen clocks.

// File: rtl/pwm_tbase_pkg.sv
`timescale 1ns/1ps
package pwm_tbase_pkg;

  typedef enum logic [1:0] {
    REG_PERIOD = 2'd0,
    REG_PHASE  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  typedef enum logic {
    SYNC_SRC_ZERO = 1'b0,
    SYNC_SRC_PASS = 1'b1
  } sync_src_e;

  localparam int CTRL_PHASE_EN_BIT = 0;
  localparam int CTRL_SYNC_SRC_BIT = 1;

endpackage

// File: rtl/pwm_tbase_regs.sv
`timescale 1ns/1ps
module pwm_tbase_regs
  import pwm_tbase_pkg::*;
#(
  parameter int CW        = 16,
  parameter int RESET_PRD = 600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          at_zero,
  output logic [CW-1:0] shadow_prd,
  output logic [CW-1:0] active_prd,
  output logic [CW-1:0] eff_prd,
  output logic [CW-1:0] phase_val,
  output logic          phase_en,
  output sync_src_e     sync_src
);

  localparam logic [CW-1:0] PRD_INIT = CW'(RESET_PRD);

  // pending registers written by software
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_prd <= PRD_INIT;
      phase_val  <= '0;
      phase_en   <= 1'b0;
      sync_src   <= SYNC_SRC_ZERO;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        REG_PERIOD: shadow_prd <= wr_data;
        REG_PHASE:  phase_val  <= wr_data;
        REG_CTRL: begin
          phase_en <= wr_data[CTRL_PHASE_EN_BIT];
          sync_src <= sync_src_e'(wr_data[CTRL_SYNC_SRC_BIT]);
        end
        default: ;
      endcase
    end
  end

  // the running period copies the pending value only at the valley
  always_ff @(posedge clk) begin
    if (!rst_n) active_prd <= PRD_INIT;
    else if (at_zero) active_prd <= shadow_prd;
  end

  // the period the counter steps against in this cycle
  assign eff_prd = at_zero ? shadow_prd : active_prd;

  a_r5_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !at_zero |=> $stable(active_prd));

  a_r5_active_takes_pending: assert property (@(posedge clk) disable iff (!rst_n)
    at_zero |=> active_prd == $past(shadow_prd));

  a_r11_spare_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=>
      ($stable(shadow_prd) && $stable(phase_val) && $stable(phase_en) && $stable(sync_src)));

endmodule

// File: rtl/pwm_tbase_counter.sv
`timescale 1ns/1ps
module pwm_tbase_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] eff_prd,
  input  logic          load_req,
  input  logic [CW-1:0] phase_val,
  output logic [CW-1:0] count_q,
  output logic          dir_up_q
);

  // returns {direction of the step, next count}
  function automatic logic [CW:0] step_fn(input logic [CW-1:0] cnt,
                                          input logic          up,
                                          input logic [CW-1:0] prd);
    logic [CW:0] r;
    if (cnt == '0 && prd == '0)      r = {1'b1, {CW{1'b0}}};
    else if (up && cnt >= prd)       r = {1'b0, cnt - 1'b1};
    else if (up)                     r = {1'b1, cnt + 1'b1};
    else if (cnt == '0)              r = {1'b1, CW'(1)};
    else                             r = {1'b0, cnt - 1'b1};
    return r;
  endfunction

  logic [CW:0] nxt;
  assign nxt = step_fn(count_q, dir_up_q, eff_prd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      dir_up_q <= 1'b1;
    end else if (load_req) begin
      count_q  <= phase_val;
      dir_up_q <= 1'b1;
    end else begin
      count_q  <= nxt[CW-1:0];
      dir_up_q <= nxt[CW];
    end
  end

  a_r6_phase_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> (count_q == $past(phase_val) && dir_up_q));

  a_r2_climb: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req && dir_up_q && count_q < eff_prd) |=> count_q == $past(count_q) + 1'b1);

  a_r9_turn_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req && dir_up_q && count_q >= eff_prd && eff_prd != '0) |=>
      (!dir_up_q && count_q == $past(count_q) - 1'b1));

  a_r3_turn_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req && !dir_up_q && count_q == '0 && eff_prd != '0) |=>
      (dir_up_q && count_q == CW'(1)));

  a_r10_hold_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req && count_q == '0 && eff_prd == '0) |=> (count_q == '0 && dir_up_q));

endmodule

// File: rtl/pwm_tbase_events.sv
`timescale 1ns/1ps
module pwm_tbase_events
  import pwm_tbase_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0] count_q,
  input  logic [CW-1:0] active_prd,
  input  logic          sync_in,
  input  sync_src_e     sync_src,
  output logic          zero_evt,
  output logic          period_evt,
  output logic          sync_out
);

  function automatic logic is_peak(input logic [CW-1:0] cnt, input logic [CW-1:0] prd);
    return (prd != '0) && (cnt == prd);
  endfunction

  assign zero_evt   = (count_q == '0);
  assign period_evt = is_peak(count_q, active_prd);
  assign sync_out   = (sync_src == SYNC_SRC_PASS) ? sync_in : zero_evt;

endmodule

// File: rtl/pwm_tbase.sv
`timescale 1ns/1ps
module pwm_tbase
  import pwm_tbase_pkg::*;
#(
  parameter int CW        = 16,
  parameter int RESET_PRD = 600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          sync_in,
  output logic [CW-1:0] count,
  output logic          zero_evt,
  output logic          period_evt,
  output logic          dir_up,
  output logic          sync_out
);

  logic [CW-1:0] shadow_prd, active_prd, eff_prd, phase_val;
  logic          phase_en;
  sync_src_e     sync_src;
  logic          at_zero;
  logic          load_req;

  assign at_zero  = (count == '0);
  assign load_req = sync_in & phase_en;

  pwm_tbase_regs #(.CW(CW), .RESET_PRD(RESET_PRD)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .at_zero(at_zero), .shadow_prd(shadow_prd), .active_prd(active_prd),
    .eff_prd(eff_prd), .phase_val(phase_val), .phase_en(phase_en), .sync_src(sync_src)
  );

  pwm_tbase_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .eff_prd(eff_prd), .load_req(load_req),
    .phase_val(phase_val), .count_q(count), .dir_up_q(dir_up)
  );

  pwm_tbase_events #(.CW(CW)) u_evt (
    .count_q(count), .active_prd(active_prd), .sync_in(sync_in), .sync_src(sync_src),
    .zero_evt(zero_evt), .period_evt(period_evt), .sync_out(sync_out)
  );

  a_r4_zero_single: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && eff_prd != '0 && !load_req) |=> !zero_evt);

  a_r4_peak_single: assert property (@(posedge clk) disable iff (!rst_n)
    (period_evt && !load_req) |=> !period_evt);

  a_r7_sync_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && !phase_en && count == '0 && eff_prd != '0) |=> count == CW'(1));

endmodule

// File: tb/pwm_tbase_test.sv
`timescale 1ns/1ps
module pwm_tbase_test;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          sync_in = 1'b0;
  logic [CW-1:0] count;
  logic          zero_evt, period_evt, dir_up, sync_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  pwm_tbase #(.CW(CW), .RESET_PRD(5)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .count(count), .zero_evt(zero_evt), .period_evt(period_evt),
    .dir_up(dir_up), .sync_out(sync_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_reg(input int addr, input int data);
    wr_en = 1'b1; wr_addr = addr[1:0]; wr_data = data[CW-1:0];
    step();
    wr_en = 1'b0;
  endtask

  task automatic pulse_sync();
    sync_in = 1'b1;
    step();
    sync_in = 1'b0;
  endtask

  // walks until the counter reads 0; returns the highest value seen
  task automatic wait_zero(output int peak);
    int guard = 0;
    peak = 0;
    while (count != 0 && guard < 2000) begin
      if (int'(count) > peak) peak = int'(count);
      step();
      guard++;
    end
    chk("R2 reach valley", int'(count), 0);
  endtask

  // counter reads 0 now; checks one whole carrier of period p
  task automatic check_carrier(input int p, input bit zero_src);
    for (int i = 1; i <= 2 * p; i++) begin
      int e;
      step();
      e = (i <= p) ? i : 2 * p - i;
      chk("R2 count", int'(count), e);
      chk("R3 dir_up", int'(dir_up), (i <= p) ? 1 : 0);
      chk("R4 zero_evt", int'(zero_evt), (i == 2 * p) ? 1 : 0);
      chk("R4 period_evt", int'(period_evt), (i == p) ? 1 : 0);
      if (zero_src) chk("R8 sync_out zero source", int'(sync_out), (i == 2 * p) ? 1 : 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) step();
    rst_n = 1'b1;
    chk("R1 count", int'(count), 0);
    chk("R1 dir_up", int'(dir_up), 1);
    chk("R1 zero_evt", int'(zero_evt), 1);
    chk("R1 period_evt", int'(period_evt), 0);
    chk("R1 sync_out zero source", int'(sync_out), 1);
    check_carrier(5, 1'b1);   // R1 period 5 from reset
  endtask

  task automatic t_shadow();
    int pk;
    step(); step();
    chk("R5 mid carrier", int'(count), 2);
    write_reg(0, 3);
    chk("R5 unchanged step", int'(count), 3);
    wait_zero(pk);
    chk("R5 old peak kept", pk, 5);
    check_carrier(3, 1'b1);
  endtask

  task automatic t_phase();
    write_reg(1, 2);
    write_reg(2, 1);
    step();
    pulse_sync();
    chk("R6 phase loaded", int'(count), 2);
    chk("R6 dir after load", int'(dir_up), 1);
    step();
    chk("R6 climbs after load", int'(count), 3);
    chk("R4 peak after load", int'(period_evt), 1);
    step();
    chk("R3 falls after peak", int'(count), 2);
    chk("R3 dir down", int'(dir_up), 0);
  endtask

  task automatic t_above();
    int pk;
    write_reg(1, 7);
    pulse_sync();
    chk("R9 load above period", int'(count), 7);
    chk("R9 dir after load", int'(dir_up), 1);
    chk("R4 no peak above", int'(period_evt), 0);
    step();
    chk("R9 turns down", int'(count), 6);
    chk("R9 dir down", int'(dir_up), 0);
    wait_zero(pk);
    check_carrier(3, 1'b1);
  endtask

  task automatic t_ignored();
    int pk;
    write_reg(2, 0);
    wait_zero(pk);
    pulse_sync();
    chk("R7 sync ignored count", int'(count), 1);
    chk("R7 sync ignored dir", int'(dir_up), 1);
    step();
    chk("R7 keeps climbing", int'(count), 2);
  endtask

  task automatic t_sync_out();
    int pk;
    wait_zero(pk);
    chk("R8 zero source at valley", int'(sync_out), 1);
    step();
    sync_in = 1'b1; #0.5;
    chk("R8 zero source ignores sync_in", int'(sync_out), 0);
    sync_in = 1'b0;
    write_reg(2, 2);
    wait_zero(pk);
    chk("R8 pass source quiet at valley", int'(sync_out), 0);
    sync_in = 1'b1; #0.5;
    chk("R8 pass source follows", int'(sync_out), 1);
    step();
    sync_in = 1'b0; #0.5;
    chk("R8 pass source drops", int'(sync_out), 0);
    chk("R7 pass mode no load", int'(count), 1);
  endtask

  task automatic t_spare();
    int pk;
    write_reg(2, 0);
    write_reg(3, 255);
    wait_zero(pk);
    chk("R11 control kept zero source", int'(sync_out), 1);
    pulse_sync();
    chk("R11 phase loading still off", int'(count), 1);
    wait_zero(pk);
    chk("R11 period kept", pk, 3);
    check_carrier(3, 1'b1);
  endtask

  task automatic t_zero_period();
    int pk;
    write_reg(0, 0);
    wait_zero(pk);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R10 held at zero", int'(count), 0);
      chk("R10 dir held up", int'(dir_up), 1);
      chk("R10 no peak", int'(period_evt), 0);
    end
    write_reg(0, 4);
    chk("R10 still zero at write", int'(count), 0);
    check_carrier(4, 1'b1);
  endtask

  task automatic t_full_width();
    int pk;
    write_reg(0, 255);
    wait_zero(pk);
    check_carrier(255, 1'b1);
  endtask

  initial begin
    t_reset();
    t_shadow();
    t_phase();
    t_above();
    t_ignored();
    t_sync_out();
    t_spare();
    t_zero_period();
    t_full_width();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule